// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Sequencer

This block walks a linked list of transfer descriptors stored in a word-addressed memory. Software places descriptors in memory and writes the address of the first one into the next-pointer register. It then sets the start bit in the control register. For each descriptor the sequencer first reads the word that holds the control byte. If the ownership bit in that byte is set, it reads the address, pointer and length words. It then presents one transfer request to an external data mover and holds it until the mover reports completion. The byte count and status returned by the mover are written back into the descriptor, and the walk continues at the descriptor's next pointer.

The walk stops at the first descriptor whose ownership bit is clear. In polling mode the sequencer instead waits a programmable number of clocks and reads that descriptor's control word again, so software can append work to a running chain. Completion can optionally hand the descriptor back to software by clearing its ownership bit. A transfer error can optionally halt the chain. A software reset bit in the control register returns the sequencer to idle at once.

The sequencer is a single state machine with eight states. IDLE waits for start. RD_CTRL reads the control word. CHK_CTRL tests ownership and branches to RD_ISSUE (owned), POLL_DLY (not owned, polling) or IDLE (not owned, chain complete). POLL_DLY returns to RD_CTRL when the delay expires. RD_ISSUE and RD_CAPT alternate four times to fetch the source, destination, next pointer and length. XFER holds the request until done and then goes to WB. WB writes the descriptor back and goes to RD_CTRL, or to IDLE when an error halts the chain. A software reset moves every state to IDLE.

Top module: `sgq_chain_seq`

## Requirements
- R1: A descriptor at byte address B uses these words: B+0 source address, B+8 destination address, B+16 next-descriptor pointer, B+24 byte count in bits 15:0, and B+28 holding the control byte in bits 31:24, status in 23:16 and transferred count in 15:0. The transfer request carries the source, destination and byte count. It also carries control byte bit 0 as end of packet, bit 1 as fixed read address and bit 2 as fixed write address.
- R2: A write to the control register (select 1) with bit 5 set while idle starts the walk at the address held in the next-pointer register (select 2). The first action is a read of that descriptor's control word. Starting clears status bits 3:0.
- R3: A descriptor is transferred only when control byte bit 7 (owned by hardware) is set. With control register bit 18 clear, an unowned descriptor ends the walk: status bit 3 (chain complete) is set and status bit 4 (busy) reads 0.
- R4: While a transfer request is pending, its fields stay stable and the sequencer makes no memory access.
- R5: In the cycle after the mover reports done, the sequencer writes word B+28 with the mover's count in bits 15:0 and the mover's status in bits 23:16. Bits 31:24 hold the control byte with bit 7 cleared when control register bit 17 is 0, and unchanged when bit 17 is 1.
- R6: After write-back, the descriptor's next pointer is loaded into the next-pointer register and that descriptor is processed next, so a chain of N owned descriptors yields N transfers.
- R7: Each write-back sets status bit 2. It sets status bit 1 when mover status bit 7 is set, and status bit 0 when any of mover status bits 5:0 is set.
- R8: With control register bit 6 set, a write-back that sets the error bit returns the sequencer to idle without setting chain complete.
- R9: With control register bit 18 set, an unowned descriptor's control word is read again after the delay in control bits 26:19, with no memory access during the wait. Once software sets the ownership bit, the descriptor is transferred.
- R10: A control write with bit 16 set returns the sequencer to idle on the next cycle. It drops any pending request, skips write-back, clears status bits 3:0, and takes priority over bit 5 in the same write.
- R11: After reset all registers read 0. The control register reads back bits 6, 17, 18 and 26:19 and reads 0 elsewhere. Status bit 4 reads 1 exactly while the walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 control, 2 next pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel (combinational) |
| mem_req | output | 1 | Descriptor memory access strobe |
| mem_we | output | 1 | Descriptor memory write enable |
| mem_addr | output | ADDR_W | Descriptor memory byte address |
| mem_wdata | output | 32 | Descriptor memory write data |
| mem_rdata | input | 32 | Descriptor memory read data, one cycle after mem_req |
| xfer_req | output | 1 | Transfer request, held until xfer_done |
| xfer_src | output | ADDR_W | Transfer source address |
| xfer_dst | output | ADDR_W | Transfer destination address |
| xfer_len | output | 16 | Transfer byte count |
| xfer_eop | output | 1 | End-of-packet flag from the control byte |
| xfer_rd_fixed | output | 1 | Fixed read address flag |
| xfer_wr_fixed | output | 1 | Fixed write address flag |
| xfer_done | input | 1 | Mover completion, sampled while xfer_req is high |
| xfer_count | input | 16 | Bytes moved, valid with xfer_done |
| xfer_status | input | 8 | Mover status byte, valid with xfer_done |

## Verification
The assertions check four rules on every clock cycle. A pending request holds stable and keeps the memory port quiet. A completed transfer is followed at once by a write-back. The memory port stays silent during the polling delay. A start or a software reset reaches the state machine on the next cycle. The contents of each write-back cannot be shown by the assertions, and only the bench scenarios cover them. The same holds for the ownership-bit handling under both settings of bit 17, the status flags derived from the mover status, chain length, the halt on error, and resumption once software hands a polled descriptor back to hardware.

// File: rtl/sgq_pkg.sv
package sgq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_CTRL,
        S_CHK_CTRL,
        S_POLL_DLY,
        S_RD_ISSUE,
        S_RD_CAPT,
        S_XFER,
        S_WB
    } seq_state_t;

    localparam int LEN_W        = 16;
    localparam int CTL_WORD_OFS = 28;   // byte offset of control/status/count word
    localparam int FIELD_SHIFT  = 3;    // fetched fields sit 8 bytes apart
    localparam int NUM_FIELDS   = 4;

    // register selects
    localparam logic [1:0] SEL_STATUS = 2'd0;
    localparam logic [1:0] SEL_CTRL   = 2'd1;
    localparam logic [1:0] SEL_NEXT   = 2'd2;

    // control register bit positions
    localparam int CR_START    = 5;
    localparam int CR_STOP_ERR = 6;
    localparam int CR_SRST     = 16;
    localparam int CR_KEEP_OWN = 17;
    localparam int CR_POLL     = 18;
    localparam int CR_PDLY_LSB = 19;

    // status register bit positions
    localparam int SR_ERR   = 0;
    localparam int SR_EOP   = 1;
    localparam int SR_DESC  = 2;
    localparam int SR_CHAIN = 3;
    localparam int SR_BUSY  = 4;

    // descriptor control byte bits
    localparam int DC_EOP   = 0;
    localparam int DC_RDFIX = 1;
    localparam int DC_WRFIX = 2;
    localparam int DC_OWN   = 7;

    // mover status byte
    localparam int MS_EOP = 7;
    localparam logic [7:0] MS_ERR_MASK = 8'h3F;

endpackage

// File: rtl/sgq_poll_timer.sv
module sgq_poll_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sgq_regs.sv
module sgq_regs
    import sgq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PDLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              start_p,
    output logic              srst_p,
    output logic              cfg_stop_err,
    output logic              cfg_keep_own,
    output logic              cfg_poll,
    output logic [PDLY_W-1:0] cfg_pdly,
    output logic [ADDR_W-1:0] next_ptr,
    input  logic              busy,
    input  logic              ev_desc,
    input  logic              ev_eop,
    input  logic              ev_err,
    input  logic              ev_chain,
    input  logic              nxt_load,
    input  logic [ADDR_W-1:0] nxt_val
);
    logic       ctrl_wr;
    logic [3:0] sticky;
    logic       unused_wbits;

    assign ctrl_wr = reg_we && (reg_sel == SEL_CTRL);
    assign srst_p  = ctrl_wr && reg_wdata[CR_SRST];
    assign start_p = ctrl_wr && reg_wdata[CR_START] && !reg_wdata[CR_SRST];
    assign unused_wbits = ^{reg_wdata[4:0], reg_wdata[15:7], reg_wdata[31:CR_PDLY_LSB+PDLY_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_stop_err <= 1'b0;
            cfg_keep_own <= 1'b0;
            cfg_poll     <= 1'b0;
            cfg_pdly     <= '0;
        end else if (ctrl_wr) begin
            cfg_stop_err <= reg_wdata[CR_STOP_ERR];
            cfg_keep_own <= reg_wdata[CR_KEEP_OWN];
            cfg_poll     <= reg_wdata[CR_POLL];
            cfg_pdly     <= reg_wdata[CR_PDLY_LSB +: PDLY_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            next_ptr <= '0;
        else if (nxt_load)
            next_ptr <= nxt_val;
        else if (reg_we && reg_sel == SEL_NEXT)
            next_ptr <= reg_wdata[ADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sticky <= '0;
        else if (srst_p || (start_p && !busy))
            sticky <= '0;
        else begin
            if (ev_err)   sticky[SR_ERR]   <= 1'b1;
            if (ev_eop)   sticky[SR_EOP]   <= 1'b1;
            if (ev_desc)  sticky[SR_DESC]  <= 1'b1;
            if (ev_chain) sticky[SR_CHAIN] <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_STATUS: begin
                reg_rdata[3:0]     = sticky;
                reg_rdata[SR_BUSY] = busy;
            end
            SEL_CTRL: begin
                reg_rdata[CR_STOP_ERR]               = cfg_stop_err;
                reg_rdata[CR_KEEP_OWN]               = cfg_keep_own;
                reg_rdata[CR_POLL]                   = cfg_poll;
                reg_rdata[CR_PDLY_LSB +: PDLY_W]     = cfg_pdly;
            end
            SEL_NEXT: reg_rdata = 32'(next_ptr);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sgq_fsm.sv
module sgq_fsm
    import sgq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_p,
    input  logic              srst_p,
    input  logic              cfg_stop_err,
    input  logic              cfg_keep_own,
    input  logic              cfg_poll,
    input  logic [ADDR_W-1:0] next_ptr,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              xfer_eop,
    output logic              xfer_rd_fixed,
    output logic              xfer_wr_fixed,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_count,
    input  logic [7:0]        xfer_status,
    output logic              busy,
    output logic              ev_desc,
    output logic              ev_eop,
    output logic              ev_err,
    output logic              ev_chain,
    output logic              nxt_load,
    output logic [ADDR_W-1:0] nxt_val,
    output seq_state_t        state
);
    localparam int IDX_W = $clog2(NUM_FIELDS);

    seq_state_t        nstate;
    logic [ADDR_W-1:0] cur_ptr;
    logic [ADDR_W-1:0] d_src, d_dst, d_next;
    logic [LEN_W-1:0]  d_len;
    logic [7:0]        d_ctl;
    logic [IDX_W-1:0]  fidx;
    logic [LEN_W-1:0]  wb_count;
    logic [7:0]        wb_status;
    logic              owned;
    logic              wb_err;
    logic [7:0]        wb_ctl;
    logic              unused_rd;

    assign owned     = mem_rdata[24 + DC_OWN];
    assign wb_err    = |(wb_status & MS_ERR_MASK);
    assign unused_rd = ^mem_rdata[31:LEN_W];

    always_comb begin
        wb_ctl = d_ctl;
        if (!cfg_keep_own)
            wb_ctl[DC_OWN] = 1'b0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else if (srst_p)
            state <= S_IDLE;
        else
            state <= nstate;
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:     if (start_p) nstate = S_RD_CTRL;
            S_RD_CTRL:  nstate = S_CHK_CTRL;
            S_CHK_CTRL: begin
                if (owned)         nstate = S_RD_ISSUE;
                else if (cfg_poll) nstate = S_POLL_DLY;
                else               nstate = S_IDLE;
            end
            S_POLL_DLY: if (tmr_expired) nstate = S_RD_CTRL;
            S_RD_ISSUE: nstate = S_RD_CAPT;
            S_RD_CAPT:  nstate = (fidx == IDX_W'(NUM_FIELDS - 1)) ? S_XFER : S_RD_ISSUE;
            S_XFER:     if (xfer_done) nstate = S_WB;
            S_WB:       nstate = (wb_err && cfg_stop_err) ? S_IDLE : S_RD_CTRL;
            default:    nstate = S_IDLE;
        endcase
    end

    // descriptor datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ptr   <= '0;
            d_src     <= '0;
            d_dst     <= '0;
            d_next    <= '0;
            d_len     <= '0;
            d_ctl     <= '0;
            fidx      <= '0;
            wb_count  <= '0;
            wb_status <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    fidx <= '0;
                    if (start_p) cur_ptr <= next_ptr;
                end
                S_CHK_CTRL: d_ctl <= mem_rdata[31:24];
                S_RD_CAPT: begin
                    fidx <= fidx + IDX_W'(1);
                    unique case (fidx)
                        2'd0:    d_src  <= mem_rdata[ADDR_W-1:0];
                        2'd1:    d_dst  <= mem_rdata[ADDR_W-1:0];
                        2'd2:    d_next <= mem_rdata[ADDR_W-1:0];
                        default: d_len  <= mem_rdata[LEN_W-1:0];
                    endcase
                end
                S_XFER: if (xfer_done) begin
                    wb_count  <= xfer_count;
                    wb_status <= xfer_status;
                end
                S_WB: cur_ptr <= d_next;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_ptr + ADDR_W'(CTL_WORD_OFS);
        mem_wdata = '0;
        tmr_load  = 1'b0;
        ev_chain  = 1'b0;
        ev_desc   = 1'b0;
        ev_eop    = 1'b0;
        ev_err    = 1'b0;
        nxt_load  = 1'b0;
        unique case (state)
            S_RD_CTRL:  mem_req = 1'b1;
            S_CHK_CTRL: begin
                tmr_load = !owned && cfg_poll;
                ev_chain = !owned && !cfg_poll;
            end
            S_RD_ISSUE: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + ADDR_W'({fidx, {FIELD_SHIFT{1'b0}}});
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {wb_ctl, wb_status, wb_count};
                ev_desc   = 1'b1;
                ev_eop    = wb_status[MS_EOP];
                ev_err    = wb_err;
                nxt_load  = 1'b1;
            end
            default: ;
        endcase
    end

    assign nxt_val       = d_next;
    assign busy          = (state != S_IDLE);
    assign xfer_req      = (state == S_XFER);
    assign xfer_src      = d_src;
    assign xfer_dst      = d_dst;
    assign xfer_len      = d_len;
    assign xfer_eop      = d_ctl[DC_EOP];
    assign xfer_rd_fixed = d_ctl[DC_RDFIX];
    assign xfer_wr_fixed = d_ctl[DC_WRFIX];
endmodule

// File: rtl/sgq_chain_seq.sv
module sgq_chain_seq
    import sgq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PDLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    output logic [15:0]       xfer_len,
    output logic              xfer_eop,
    output logic              xfer_rd_fixed,
    output logic              xfer_wr_fixed,
    input  logic              xfer_done,
    input  logic [15:0]       xfer_count,
    input  logic [7:0]        xfer_status
);
    logic              start_p, srst_p;
    logic              cfg_stop_err, cfg_keep_own, cfg_poll;
    logic [PDLY_W-1:0] cfg_pdly;
    logic [ADDR_W-1:0] next_ptr, nxt_val;
    logic              busy, ev_desc, ev_eop, ev_err, ev_chain, nxt_load;
    logic              tmr_load, tmr_expired;
    seq_state_t        seq_state;

    sgq_regs #(.ADDR_W(ADDR_W), .PDLY_W(PDLY_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .start_p(start_p), .srst_p(srst_p),
        .cfg_stop_err(cfg_stop_err), .cfg_keep_own(cfg_keep_own),
        .cfg_poll(cfg_poll), .cfg_pdly(cfg_pdly), .next_ptr(next_ptr),
        .busy(busy), .ev_desc(ev_desc), .ev_eop(ev_eop), .ev_err(ev_err),
        .ev_chain(ev_chain), .nxt_load(nxt_load), .nxt_val(nxt_val)
    );

    sgq_poll_timer #(.W(PDLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(cfg_pdly),
        .expired(tmr_expired)
    );

    sgq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_p(start_p), .srst_p(srst_p),
        .cfg_stop_err(cfg_stop_err), .cfg_keep_own(cfg_keep_own), .cfg_poll(cfg_poll),
        .next_ptr(next_ptr), .tmr_expired(tmr_expired), .tmr_load(tmr_load),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .xfer_req(xfer_req), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_len(xfer_len), .xfer_eop(xfer_eop), .xfer_rd_fixed(xfer_rd_fixed),
        .xfer_wr_fixed(xfer_wr_fixed), .xfer_done(xfer_done),
        .xfer_count(xfer_count), .xfer_status(xfer_status),
        .busy(busy), .ev_desc(ev_desc), .ev_eop(ev_eop), .ev_err(ev_err),
        .ev_chain(ev_chain), .nxt_load(nxt_load), .nxt_val(nxt_val),
        .state(seq_state)
    );
endmodule

// File: rtl/sgq_chain_seq_chk.sv
module sgq_chain_seq_chk
    import sgq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [31:0]       reg_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic              xfer_req,
    input logic [ADDR_W-1:0] xfer_src,
    input logic [ADDR_W-1:0] xfer_dst,
    input logic [15:0]       xfer_len,
    input logic              xfer_done,
    input logic              busy,
    input seq_state_t        seq_state
);
    logic srst_w, start_w;
    assign srst_w  = reg_we && reg_sel == SEL_CTRL && reg_wdata[CR_SRST];
    assign start_w = reg_we && reg_sel == SEL_CTRL && reg_wdata[CR_START] && !reg_wdata[CR_SRST];

    // R4: pending request stays stable
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_done && !srst_w |=>
            xfer_req && $stable(xfer_src) && $stable(xfer_dst) && $stable(xfer_len));

    // R4: no memory traffic during a transfer
    p_quiet_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !mem_req);

    // R5: write-back follows completion
    p_wb_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_done && !srst_w |=> mem_req && mem_we && !xfer_req);

    // R9: no memory traffic while waiting to poll
    p_poll_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == S_POLL_DLY |-> !mem_req);

    // R10: software reset idles the sequencer
    p_srst_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_w |=> !busy && !xfer_req && !mem_req);

    // R2: start from idle issues a control-word read
    p_start_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_w && !busy |=> mem_req && !mem_we);

    // R11: a transfer only happens while busy
    p_busy_xfer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> busy);
endmodule

bind sgq_chain_seq sgq_chain_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .xfer_req(xfer_req), .xfer_src(xfer_src),
    .xfer_dst(xfer_dst), .xfer_len(xfer_len), .xfer_done(xfer_done),
    .busy(busy), .seq_state(seq_state)
);

// File: tb/tb_sgq_chain_seq.sv
`timescale 1ns/1ps
module tb_sgq_chain_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        xfer_req, xfer_eop, xfer_rd_fixed, xfer_wr_fixed;
    logic [31:0] xfer_src, xfer_dst;
    logic [15:0] xfer_len;
    logic        xfer_done;
    logic [15:0] xfer_count;
    logic [7:0]  xfer_status;

    always #4 clk = ~clk;

    sgq_chain_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .xfer_req(xfer_req), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_len(xfer_len), .xfer_eop(xfer_eop), .xfer_rd_fixed(xfer_rd_fixed),
        .xfer_wr_fixed(xfer_wr_fixed), .xfer_done(xfer_done),
        .xfer_count(xfer_count), .xfer_status(xfer_status)
    );

    // descriptor memory, 64 words, read data one cycle after request
    logic [31:0] mem [64];
    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        if (mem_req) mem_rdata <= mem[mem_addr[7:2]];
    end

    // data mover stub
    logic [2:0]  stub_cnt = '0;
    logic        stub_stall = 1'b0;
    logic [7:0]  stub_status = '0;
    int          n_xfers = 0;
    logic [31:0] rec_src, rec_dst;
    logic [15:0] rec_len;
    logic [2:0]  rec_flags;
    always @(posedge clk) begin
        if (!xfer_req) stub_cnt <= '0;
        else if (stub_cnt != 3'd7) stub_cnt <= stub_cnt + 3'd1;
        if (xfer_req && xfer_done) begin
            n_xfers   <= n_xfers + 1;
            rec_src   <= xfer_src;
            rec_dst   <= xfer_dst;
            rec_len   <= xfer_len;
            rec_flags <= {xfer_wr_fixed, xfer_rd_fixed, xfer_eop};
        end
    end
    assign xfer_done   = xfer_req && !stub_stall && (stub_cnt >= 3'd3);
    assign xfer_count  = xfer_len - 16'd1;
    assign xfer_status = stub_status;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rreg(input logic [1:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            rreg(2'd0, s);
            if (!s[4]) break;
        end
    endtask

    task automatic put_desc(input int base, input logic [31:0] src, input logic [31:0] dst,
                            input logic [31:0] nxt, input logic [15:0] len, input logic [7:0] ctl);
        mem[base/4 + 0] = src;
        mem[base/4 + 2] = dst;
        mem[base/4 + 4] = nxt;
        mem[base/4 + 6] = {16'h0, len};
        mem[base/4 + 7] = {ctl, 24'h0};
    endtask

    // vector: {mover status[8], len[16], eop, rdfix, wrfix, keep_own, stop_err}
    localparam logic [28:0] VEC [5] = '{
        {8'h00, 16'h0040, 5'b10000},
        {8'h80, 16'h05EE, 5'b01010},
        {8'h04, 16'h0010, 5'b10100},
        {8'h21, 16'hFFFF, 5'b01101},
        {8'h00, 16'h0001, 5'b00011}
    };

    initial begin
        logic [31:0] r;
        int base_x;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset values
        rreg(2'd0, r); chk(r == 32'h0, "R11 status reset", r, 32'h0);
        rreg(2'd1, r); chk(r == 32'h0, "R11 control reset", r, 32'h0);
        rreg(2'd2, r); chk(r == 32'h0, "R11 next reset", r, 32'h0);
        chk(!xfer_req && !mem_req, "R11 idle outputs", {30'h0, xfer_req, mem_req}, 32'h0);

        // vector table: single descriptor, then unowned successor
        for (int v = 0; v < 5; v++) begin
            logic [7:0]  mst;
            logic [15:0] len;
            logic        eop, rdf, wrf, keep, stp, err;
            logic [7:0]  ctl, ctl_exp;
            logic [31:0] st_exp;
            {mst, len, eop, rdf, wrf, keep, stp} = VEC[v];
            ctl = {1'b1, 4'b0, wrf, rdf, eop};
            ctl_exp = keep ? ctl : {1'b0, ctl[6:0]};
            err = |mst[5:0];
            put_desc(0, 32'h1000 + v, 32'h2000 + v, 32'h40, len, ctl);
            mem[23] = '0;
            stub_status = mst;
            base_x = n_xfers;
            wreg(2'd2, 32'h0);
            wreg(2'd1, (32'(keep) << 17) | (32'(stp) << 6) | 32'h20);
            wait_idle();
            chk(n_xfers == base_x + 1, "R3 one transfer", n_xfers, base_x + 1);
            chk(rec_src == 32'h1000 + v, "R1 source", rec_src, 32'h1000 + v);
            chk(rec_dst == 32'h2000 + v, "R1 destination", rec_dst, 32'h2000 + v);
            chk(rec_len == len, "R1 length", {16'h0, rec_len}, {16'h0, len});
            chk(rec_flags == {wrf, rdf, eop}, "R1 flags", {29'h0, rec_flags}, {29'h0, wrf, rdf, eop});
            chk(mem[7] == {ctl_exp, mst, len - 16'd1}, "R5 write-back", mem[7], {ctl_exp, mst, len - 16'd1});
            st_exp = {27'h0, 1'b0, !(err && stp), 1'b1, mst[7], err};
            rreg(2'd0, r); chk(r == st_exp, "R7 R8 status", r, st_exp);
            rreg(2'd2, r); chk(r == 32'h40, "R6 next pointer", r, 32'h40);
        end

        // R6: chain of three owned descriptors
        put_desc(0,   32'hA0, 32'hB0, 32'h40, 16'd8, 8'h80);
        put_desc(64,  32'hA1, 32'hB1, 32'h80, 16'd9, 8'h80);
        put_desc(128, 32'hA2, 32'hB2, 32'hC0, 16'd10, 8'h80);
        mem[55] = '0;
        stub_status = '0;
        base_x = n_xfers;
        wreg(2'd2, 32'h0);
        wreg(2'd1, 32'h20);
        wait_idle();
        chk(n_xfers == base_x + 3, "R6 chain transfers", n_xfers, base_x + 3);
        chk(rec_src == 32'hA2, "R6 last source", rec_src, 32'hA2);
        rreg(2'd2, r); chk(r == 32'hC0, "R6 final pointer", r, 32'hC0);
        chk(mem[23][31] == 1'b0 && mem[39][31] == 1'b0, "R5 ownership cleared", {mem[23][31], mem[39][31]}, 0);
        rreg(2'd0, r); chk(r == 32'h0C, "R3 chain complete", r, 32'h0C);

        // R3: first descriptor unowned
        put_desc(0, 32'h1, 32'h2, 32'h40, 16'd4, 8'h00);
        base_x = n_xfers;
        wreg(2'd2, 32'h0);
        wreg(2'd1, 32'h20);
        wait_idle();
        chk(n_xfers == base_x, "R3 unowned skipped", n_xfers, base_x);
        rreg(2'd0, r); chk(r == 32'h08, "R3 chain done only", r, 32'h08);
        chk(mem[7] == 32'h0, "R3 no write-back", mem[7], 32'h0);

        // R9: polling until software hands the descriptor over
        put_desc(0, 32'h55, 32'h66, 32'h40, 16'd12, 8'h00);
        mem[23] = '0;
        base_x = n_xfers;
        wreg(2'd2, 32'h0);
        wreg(2'd1, (32'd5 << 19) | (32'd1 << 18) | 32'h20);
        repeat (40) @(negedge clk);
        rreg(2'd0, r); chk(r[4] == 1'b1, "R9 still busy while polling", r, 32'h10);
        chk(n_xfers == base_x, "R9 no transfer yet", n_xfers, base_x);
        mem[7] = {8'h80, 24'h0};
        repeat (60) @(negedge clk);
        chk(n_xfers == base_x + 1, "R9 transfer after hand-over", n_xfers, base_x + 1);
        chk(rec_src == 32'h55, "R9 polled source", rec_src, 32'h55);
        rreg(2'd0, r); chk(r[4] == 1'b1, "R9 polls successor", r, 32'h10);

        // R10: software reset while polling
        wreg(2'd1, 32'h0001_0000);
        rreg(2'd0, r); chk(r == 32'h0, "R10 reset while polling", r, 32'h0);

        // R10: software reset during a stalled transfer
        put_desc(0, 32'h77, 32'h88, 32'h40, 16'd20, 8'h80);
        stub_stall = 1'b1;
        base_x = n_xfers;
        wreg(2'd2, 32'h0);
        wreg(2'd1, 32'h20);
        for (int k = 0; k < 20 && !xfer_req; k++) @(negedge clk);
        chk(xfer_req == 1'b1, "R4 request pending", {31'h0, xfer_req}, 1);
        wreg(2'd1, 32'h0001_0000);
        chk(xfer_req == 1'b0, "R10 request dropped", {31'h0, xfer_req}, 0);
        stub_stall = 1'b0;
        repeat (10) @(negedge clk);
        chk(n_xfers == base_x, "R10 no completion", n_xfers, base_x);
        chk(mem[7] == {8'h80, 24'h0}, "R10 no write-back", mem[7], {8'h80, 24'h0});

        // R10: reset wins over start in the same write
        wreg(2'd1, 32'h0001_0020);
        rreg(2'd0, r); chk(r[4] == 1'b0, "R10 reset beats start", r, 32'h0);
        chk(n_xfers == base_x, "R10 no start", n_xfers, base_x);

        // R11: control readback mask
        wreg(2'd1, 32'hFFFF_FFFF);
        rreg(2'd1, r); chk(r == 32'h07FE_0040, "R11 control readback", r, 32'h07FE_0040);
        rreg(2'd0, r); chk(r[4] == 1'b0, "R11 not busy after reset write", r, 32'h0);
        wreg(2'd1, 32'h0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule